// File: doc/BRIEF.md
# Port-Limited Response Throttle

This block sits between a cache and the CPU on the response path and limits how many responses reach the CPU in each clock. Every response carries a kind tag, read or write. Three per-cycle budgets govern delivery: dedicated read slots, dedicated write slots, and shared slots that either kind may use. A read takes a dedicated read slot when one is left and otherwise a shared slot. A write does the same with the write and shared slots.

Up to `IN_LANES` responses can arrive in one clock. Responses that get a slot leave on the packed output lanes in the same cycle. A response that gets no slot is not pushed back to the sender. It is held in an internal FIFO and offered again at the next clock edge, ahead of anything that arrives then. The upstream side therefore sees every response accepted. The only exception is a last-resort guard that lowers `in_ready` when the FIFO cannot take a full set of lanes, and counts the cycles in which it refuses valid input.

A negative read budget selects a pass-through variant with no limiting at all.

Top module: `rsp_port_throttle`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_vld` is all zero, `in_ready` is 1 and `refuse_cnt` is 0.
- R2: In one cycle, at most RD_PORTS+SH_PORTS responses of kind read (2'b01) and at most WR_PORTS+SH_PORTS of kind write (2'b10) are delivered. A read takes a dedicated read slot before a shared one, and a write takes a dedicated write slot before a shared one.
- R3: Responses leave in arrival order. Held responses go first, oldest first, then new arrivals in ascending lane order. Delivery in a cycle stops at the first response that finds no slot. Granted responses occupy output lanes 0 upward. A lane without a response carries zero kind and data.
- R4: A response that is not delivered is not lost. It is offered again from the next clock edge onward, with priority over responses arriving at that edge.
- R5: `in_ready` is 0 exactly when fewer than IN_LANES FIFO entries are free. Valid input in such a cycle is discarded, and `refuse_cnt` increments by one for every cycle with `in_ready` low and any `in_vld` bit set.
- R6: A valid lane whose kind is neither 2'b01 nor 2'b10 raises `kind_err` in that cycle and is never delivered.
- R7: With RD_PORTS negative, every legal valid input lane i appears on output lane i in the same cycle with its kind and data, `in_ready` stays 1 and `refuse_cnt` stays 0.
- R8: When the FIFO is empty and a slot is free, a new response is delivered in the cycle it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | IN_LANES | Per-lane response valid |
| in_kind | input | 2*IN_LANES | Per-lane kind: 2'b01 read, 2'b10 write |
| in_data | input | DATA_W*IN_LANES | Per-lane response payload |
| in_ready | output | 1 | Input accepted this cycle (overflow guard) |
| out_vld | output | OUT_LANES | Per-lane delivered response valid, packed from lane 0 |
| out_kind | output | 2*OUT_LANES | Per-lane delivered kind |
| out_data | output | DATA_W*OUT_LANES | Per-lane delivered payload |
| kind_err | output | 1 | A valid input lane carries an illegal kind |
| refuse_cnt | output | CNT_W | Count of cycles in which valid input was refused |

## Verification
The checker enforces on every cycle the per-kind slot ceilings, the packing of granted lanes from lane 0, the legality of every delivered kind and the exact step of the refusal counter. It also confirms that the pass-through variant never deasserts `in_ready`. Properties of that kind cannot show that the right responses leave in the right order, that held responses come back at the next edge ahead of new ones, or that dedicated slots are used before shared ones. Only the bench's reference queue can show these, driven through directed slot-contention mixes, a FIFO fill and long random runs.

// File: rtl/rsp_thr_pkg.sv
package rsp_thr_pkg;

   typedef enum logic [1:0] {
      KIND_NONE = 2'b00,
      KIND_RD   = 2'b01,
      KIND_WR   = 2'b10,
      KIND_BAD  = 2'b11
   } rsp_kind_e;

   function automatic logic kind_legal(input logic [1:0] k);
      return (k == KIND_RD) || (k == KIND_WR);
   endfunction

endpackage

// File: rtl/rsp_thr_compact.sv
module rsp_thr_compact #(
   parameter int N     = 4,
   parameter int ENT_W = 10,
   localparam int NW   = $clog2(N + 1)
) (
   input  logic [N-1:0]            vld_i,
   input  logic [N-1:0][ENT_W-1:0] ent_i,
   output logic [N-1:0][ENT_W-1:0] ent_o,
   output logic [NW-1:0]           n_o
);

   always_comb begin
      int n;
      n = 0;
      for (int i = 0; i < N; i++) begin
         ent_o[i] = '0;
      end
      for (int i = 0; i < N; i++) begin
         if (vld_i[i]) begin
            ent_o[n] = ent_i[i];
            n++;
         end
      end
      n_o = NW'(n);
   end

endmodule

// File: rtl/rsp_thr_fifo.sv
module rsp_thr_fifo #(
   parameter int ENT_W  = 10,
   parameter int DEPTH  = 8,
   parameter int PUSH_N = 4,
   parameter int PEEK_N = 3,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int PUSH_W = $clog2(PUSH_N + 1),
   localparam int POP_W  = $clog2(PEEK_N + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PUSH_W-1:0]            push_n_i,
   input  logic [PUSH_N-1:0][ENT_W-1:0] push_ent_i,
   input  logic [POP_W-1:0]             pop_n_i,
   output logic [PEEK_N-1:0][ENT_W-1:0] peek_o,
   output logic [CNT_W-1:0]             count_o
);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] head;
   logic [CNT_W-1:0] count;

   always_ff @(posedge clk) begin
      for (int i = 0; i < PUSH_N; i++) begin
         if (i < int'(push_n_i)) begin
            mem[PTR_W'(head + PTR_W'(count) + PTR_W'(i))] <= push_ent_i[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else begin
         head  <= PTR_W'(head + PTR_W'(pop_n_i));
         count <= CNT_W'(count + CNT_W'(push_n_i) - CNT_W'(pop_n_i));
      end
   end

   for (genvar g = 0; g < PEEK_N; g++) begin : g_peek
      assign peek_o[g] = mem[PTR_W'(head + PTR_W'(g))];
   end

   assign count_o = count;

endmodule

// File: rtl/rsp_thr_alloc.sv
module rsp_thr_alloc #(
   parameter int CAND_N   = 3,
   parameter int RD_PORTS = 1,
   parameter int SH_PORTS = 1,
   parameter int WR_PORTS = 1,
   localparam int GW      = $clog2(CAND_N + 1)
) (
   input  logic [CAND_N-1:0] cand_vld_i,
   input  logic [CAND_N-1:0] cand_wr_i,
   output logic [CAND_N-1:0] grant_o,
   output logic [GW-1:0]     grant_n_o
);

   always_comb begin
      int   used_rd;
      int   used_sh;
      int   used_wr;
      int   n;
      logic go;
      used_rd = 0;
      used_sh = 0;
      used_wr = 0;
      n       = 0;
      go      = 1'b1;
      for (int i = 0; i < CAND_N; i++) begin
         grant_o[i] = 1'b0;
         if (go && cand_vld_i[i]) begin
            if (!cand_wr_i[i]) begin
               if (used_rd < RD_PORTS) begin
                  used_rd++;
                  grant_o[i] = 1'b1;
               end else if (used_sh < SH_PORTS) begin
                  used_sh++;
                  grant_o[i] = 1'b1;
               end else begin
                  go = 1'b0;
               end
            end else begin
               if (used_wr < WR_PORTS) begin
                  used_wr++;
                  grant_o[i] = 1'b1;
               end else if (used_sh < SH_PORTS) begin
                  used_sh++;
                  grant_o[i] = 1'b1;
               end else begin
                  go = 1'b0;
               end
            end
         end else begin
            go = 1'b0;
         end
         if (grant_o[i]) begin
            n++;
         end
      end
      grant_n_o = GW'(n);
   end

endmodule

// File: rtl/rsp_port_throttle.sv
module rsp_port_throttle
   import rsp_thr_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IN_LANES   = 4,
   parameter int OUT_LANES  = 3,
   parameter int FIFO_DEPTH = 8,
   parameter int RD_PORTS   = 1,
   parameter int SH_PORTS   = 1,
   parameter int WR_PORTS   = 1,
   parameter int CNT_W      = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IN_LANES-1:0]           in_vld,
   input  logic [2*IN_LANES-1:0]         in_kind,
   input  logic [DATA_W*IN_LANES-1:0]    in_data,
   output logic                          in_ready,
   output logic [OUT_LANES-1:0]          out_vld,
   output logic [2*OUT_LANES-1:0]        out_kind,
   output logic [DATA_W*OUT_LANES-1:0]   out_data,
   output logic                          kind_err,
   output logic [CNT_W-1:0]              refuse_cnt
);

   localparam int ENT_W  = DATA_W + 2;
   localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);
   localparam int IN_NW  = $clog2(IN_LANES + 1);
   localparam int OUT_NW = $clog2(OUT_LANES + 1);

   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (IN_LANES < 1 || OUT_LANES < 1) begin : g_bad_lanes
      $error("lane counts must be at least 1");
   end
   if (SH_PORTS < 0 || WR_PORTS < 0) begin : g_bad_budget
      $error("shared and write budgets must not be negative");
   end
   if (RD_PORTS >= 0 && ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0 || FIFO_DEPTH < IN_LANES)) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two no smaller than IN_LANES");
   end
   if (RD_PORTS < 0 && OUT_LANES < IN_LANES) begin : g_bad_pass
      $error("pass-through needs OUT_LANES >= IN_LANES");
   end

   logic [IN_LANES-1:0] lane_legal;

   for (genvar g = 0; g < IN_LANES; g++) begin : g_legal
      assign lane_legal[g] = in_vld[g] & kind_legal(in_kind[2*g +: 2]);
   end

   assign kind_err = |(in_vld & ~lane_legal);

   if (RD_PORTS < 0) begin : g_pass

      for (genvar g = 0; g < OUT_LANES; g++) begin : g_lane
         if (g < IN_LANES) begin : g_live
            assign out_vld[g]                 = lane_legal[g];
            assign out_kind[2*g +: 2]         = lane_legal[g] ? in_kind[2*g +: 2] : 2'b00;
            assign out_data[DATA_W*g +: DATA_W] = lane_legal[g] ? in_data[DATA_W*g +: DATA_W] : '0;
         end else begin : g_idle
            assign out_vld[g]                 = 1'b0;
            assign out_kind[2*g +: 2]         = 2'b00;
            assign out_data[DATA_W*g +: DATA_W] = '0;
         end
      end

      assign in_ready   = 1'b1;
      assign refuse_cnt = '0;

   end else begin : g_thr

      logic [IN_LANES-1:0][ENT_W-1:0]  in_ent;
      logic [IN_LANES-1:0][ENT_W-1:0]  nw_ent;
      logic [IN_NW-1:0]                nw_n;
      logic [IN_LANES-1:0]             accept;
      logic [OUT_LANES-1:0][ENT_W-1:0] peek;
      logic [FCNT_W-1:0]               fcnt;
      logic [OUT_LANES-1:0][ENT_W-1:0] cand_ent;
      logic [OUT_LANES-1:0]            cand_vld;
      logic [OUT_LANES-1:0]            cand_wr;
      logic [OUT_LANES-1:0]            grant;
      logic [OUT_NW-1:0]               grant_n;
      logic [IN_NW-1:0]                push_n;
      logic [IN_LANES-1:0][ENT_W-1:0]  push_ent;
      logic [OUT_NW-1:0]               pop_n;
      logic                            rdy;
      logic [CNT_W-1:0]                refuse_q;

      for (genvar g = 0; g < IN_LANES; g++) begin : g_pack
         assign in_ent[g] = {in_kind[2*g +: 2], in_data[DATA_W*g +: DATA_W]};
      end

      assign rdy    = (FIFO_DEPTH - int'(fcnt)) >= IN_LANES;
      assign accept = lane_legal & {IN_LANES{rdy}};

      rsp_thr_compact #(
         .N     (IN_LANES),
         .ENT_W (ENT_W)
      ) u_compact (
         .vld_i (accept),
         .ent_i (in_ent),
         .ent_o (nw_ent),
         .n_o   (nw_n)
      );

      rsp_thr_fifo #(
         .ENT_W  (ENT_W),
         .DEPTH  (FIFO_DEPTH),
         .PUSH_N (IN_LANES),
         .PEEK_N (OUT_LANES)
      ) u_fifo (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_n_i   (push_n),
         .push_ent_i (push_ent),
         .pop_n_i    (pop_n),
         .peek_o     (peek),
         .count_o    (fcnt)
      );

      always_comb begin
         for (int i = 0; i < OUT_LANES; i++) begin
            cand_vld[i] = 1'b0;
            cand_ent[i] = '0;
            if (i < int'(fcnt)) begin
               cand_vld[i] = 1'b1;
               cand_ent[i] = peek[i];
            end else if ((i - int'(fcnt)) < int'(nw_n)) begin
               cand_vld[i] = 1'b1;
               cand_ent[i] = nw_ent[i - int'(fcnt)];
            end
            cand_wr[i] = (cand_ent[i][ENT_W-1 -: 2] == KIND_WR);
         end
      end

      rsp_thr_alloc #(
         .CAND_N   (OUT_LANES),
         .RD_PORTS (RD_PORTS),
         .SH_PORTS (SH_PORTS),
         .WR_PORTS (WR_PORTS)
      ) u_alloc (
         .cand_vld_i (cand_vld),
         .cand_wr_i  (cand_wr),
         .grant_o    (grant),
         .grant_n_o  (grant_n)
      );

      always_comb begin
         int from_fifo;
         int from_new;
         from_fifo = (int'(grant_n) < int'(fcnt)) ? int'(grant_n) : int'(fcnt);
         from_new  = int'(grant_n) - from_fifo;
         pop_n     = OUT_NW'(from_fifo);
         push_n    = IN_NW'(int'(nw_n) - from_new);
         for (int k = 0; k < IN_LANES; k++) begin
            push_ent[k] = '0;
            if ((k + from_new) < IN_LANES) begin
               push_ent[k] = nw_ent[k + from_new];
            end
         end
      end

      for (genvar g = 0; g < OUT_LANES; g++) begin : g_out
         assign out_vld[g]                   = grant[g];
         assign out_kind[2*g +: 2]           = grant[g] ? cand_ent[g][ENT_W-1 -: 2] : 2'b00;
         assign out_data[DATA_W*g +: DATA_W] = grant[g] ? cand_ent[g][DATA_W-1:0] : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            refuse_q <= '0;
         end else if (!rdy && (|in_vld)) begin
            refuse_q <= refuse_q + 1'b1;
         end
      end

      assign in_ready   = rdy;
      assign refuse_cnt = refuse_q;

   end

endmodule

// File: rtl/rsp_thr_chk.sv
module rsp_thr_chk #(
   parameter int DATA_W     = 8,
   parameter int IN_LANES   = 4,
   parameter int OUT_LANES  = 3,
   parameter int FIFO_DEPTH = 8,
   parameter int RD_PORTS   = 1,
   parameter int SH_PORTS   = 1,
   parameter int WR_PORTS   = 1,
   parameter int CNT_W      = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IN_LANES-1:0]         in_vld,
   input  logic                        in_ready,
   input  logic [OUT_LANES-1:0]        out_vld,
   input  logic [2*OUT_LANES-1:0]      out_kind,
   input  logic [CNT_W-1:0]            refuse_cnt
);

   int   rd_cnt;
   int   wr_cnt;
   logic bad_out;

   always_comb begin
      rd_cnt  = 0;
      wr_cnt  = 0;
      bad_out = 1'b0;
      for (int i = 0; i < OUT_LANES; i++) begin
         if (out_vld[i]) begin
            if (out_kind[2*i +: 2] == 2'b01) rd_cnt++;
            else if (out_kind[2*i +: 2] == 2'b10) wr_cnt++;
            else bad_out = 1'b1;
         end
      end
   end

   if (RD_PORTS >= 0) begin : g_thr_props

      AST_RD_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
         rd_cnt <= RD_PORTS + SH_PORTS); // R2

      AST_WR_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
         wr_cnt <= WR_PORTS + SH_PORTS); // R2

      AST_SUM_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_cnt + wr_cnt) <= RD_PORTS + SH_PORTS + WR_PORTS); // R2

      AST_OUT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
         ((out_vld & (out_vld + 1'b1)) == '0)); // R3

      AST_REFUSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (!in_ready && (|in_vld)) |=> (refuse_cnt == CNT_W'($past(refuse_cnt) + 1'b1))); // R5

      AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (in_ready || !(|in_vld)) |=> $stable(refuse_cnt)); // R5

   end else begin : g_pass_props

      AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
         in_ready && (refuse_cnt == '0)); // R7

   end

   AST_OUT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_out); // R6

endmodule

bind rsp_port_throttle rsp_thr_chk #(
   .DATA_W     (DATA_W),
   .IN_LANES   (IN_LANES),
   .OUT_LANES  (OUT_LANES),
   .FIFO_DEPTH (FIFO_DEPTH),
   .RD_PORTS   (RD_PORTS),
   .SH_PORTS   (SH_PORTS),
   .WR_PORTS   (WR_PORTS),
   .CNT_W      (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_vld     (in_vld),
   .in_ready   (in_ready),
   .out_vld    (out_vld),
   .out_kind   (out_kind),
   .refuse_cnt (refuse_cnt)
);

// File: tb/rsp_port_throttle_bench.sv
module rsp_port_throttle_bench;

   localparam int IN_L  = 4;
   localparam int OUT_L = 3;
   localparam int PO_L  = 4;
   localparam int DW    = 8;
   localparam int DEP   = 8;
   localparam int RDP   = 1;
   localparam int SHP   = 1;
   localparam int WRP   = 1;
   localparam int CW    = 16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [IN_L-1:0]      vin = '0;
   logic [2*IN_L-1:0]    kin = '0;
   logic [DW*IN_L-1:0]   din = '0;

   logic                 in_ready;
   logic [OUT_L-1:0]     out_vld;
   logic [2*OUT_L-1:0]   out_kind;
   logic [DW*OUT_L-1:0]  out_data;
   logic                 kind_err;
   logic [CW-1:0]        refuse_cnt;

   logic                 p_ready;
   logic [PO_L-1:0]      p_vld;
   logic [2*PO_L-1:0]    p_kind;
   logic [DW*PO_L-1:0]   p_data;
   logic                 p_err;
   logic [CW-1:0]        p_refuse;

   int tests = 0;
   int fails = 0;
   int exp_refuse = 0;
   logic [DW-1:0] seq = '0;
   logic [DW+1:0] mq[$];
   bit done = 0;

   always #5 clk = ~clk;

   rsp_port_throttle #(
      .DATA_W(DW), .IN_LANES(IN_L), .OUT_LANES(OUT_L), .FIFO_DEPTH(DEP),
      .RD_PORTS(RDP), .SH_PORTS(SHP), .WR_PORTS(WRP), .CNT_W(CW)
   ) u_rsp_port_throttle (
      .clk(clk), .rst_n(rst_n), .in_vld(vin), .in_kind(kin), .in_data(din),
      .in_ready(in_ready), .out_vld(out_vld), .out_kind(out_kind),
      .out_data(out_data), .kind_err(kind_err), .refuse_cnt(refuse_cnt)
   );

   rsp_port_throttle #(
      .DATA_W(DW), .IN_LANES(IN_L), .OUT_LANES(PO_L), .FIFO_DEPTH(DEP),
      .RD_PORTS(-1), .SH_PORTS(0), .WR_PORTS(0), .CNT_W(CW)
   ) u_pass (
      .clk(clk), .rst_n(rst_n), .in_vld(vin), .in_kind(kin), .in_data(din),
      .in_ready(p_ready), .out_vld(p_vld), .out_kind(p_kind),
      .out_data(p_data), .kind_err(p_err), .refuse_cnt(p_refuse)
   );

   function automatic bit legal(input logic [1:0] k);
      return (k == 2'b01) || (k == 2'b10);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_cycle();
      logic [DW+1:0] nl[$];
      logic [DW+1:0] cand[$];
      bit            exp_ready;
      bit            exp_err;
      logic [OUT_L-1:0]   eov;
      logic [2*OUT_L-1:0] eok;
      logic [DW*OUT_L-1:0] eod;
      logic [PO_L-1:0]    pv;
      logic [2*PO_L-1:0]  pk;
      logic [DW*PO_L-1:0] pd;
      int ur, us, uw, g, popped, sent_new;
      bit go;

      chk(refuse_cnt === CW'(exp_refuse), "R5 refuse count", 64'(refuse_cnt), 64'(exp_refuse));
      exp_ready = (DEP - mq.size()) >= IN_L;
      chk(in_ready === exp_ready, "R5 in_ready", 64'(in_ready), 64'(exp_ready));

      exp_err = 0;
      pv = '0; pk = '0; pd = '0;
      for (int i = 0; i < IN_L; i++) begin
         if (vin[i] && !legal(kin[2*i +: 2])) exp_err = 1;
         if (vin[i] && legal(kin[2*i +: 2])) begin
            pv[i] = 1'b1;
            pk[2*i +: 2] = kin[2*i +: 2];
            pd[DW*i +: DW] = din[DW*i +: DW];
            if (exp_ready) nl.push_back({kin[2*i +: 2], din[DW*i +: DW]});
         end
      end
      chk(kind_err === exp_err, "R6 kind_err", 64'(kind_err), 64'(exp_err));

      for (int i = 0; i < OUT_L; i++) begin
         if (i < mq.size()) cand.push_back(mq[i]);
         else if ((i - mq.size()) < nl.size()) cand.push_back(nl[i - mq.size()]);
      end
      ur = 0; us = 0; uw = 0; g = 0; go = 1;
      eov = '0; eok = '0; eod = '0;
      for (int i = 0; i < cand.size(); i++) begin
         bit ok;
         ok = 0;
         if (go) begin
            if (cand[i][DW+1:DW] == 2'b01) begin
               if (ur < RDP) begin ur++; ok = 1; end
               else if (us < SHP) begin us++; ok = 1; end
            end else begin
               if (uw < WRP) begin uw++; ok = 1; end
               else if (us < SHP) begin us++; ok = 1; end
            end
            if (!ok) go = 0;
         end
         if (ok) begin
            eov[i] = 1'b1;
            eok[2*i +: 2] = cand[i][DW+1:DW];
            eod[DW*i +: DW] = cand[i][DW-1:0];
            g++;
         end
      end
      chk(out_vld === eov, "R2 granted lanes", 64'(out_vld), 64'(eov));
      chk((out_kind === eok) && (out_data === eod), "R3 delivered order and content",
          {out_kind, out_data}, {eok, eod});

      chk((p_vld === pv) && (p_kind === pk) && (p_data === pd) && p_ready && (p_refuse == '0),
          "R7 pass-through", {p_vld, p_data}, {pv, pd});

      popped = (g < mq.size()) ? g : mq.size();
      sent_new = g - popped;
      repeat (popped) void'(mq.pop_front());
      for (int i = sent_new; i < nl.size(); i++) mq.push_back(nl[i]);
      if (!exp_ready && (|vin)) exp_refuse++;
   endtask

   task automatic step(input logic [IN_L-1:0] v, input logic [2*IN_L-1:0] k);
      @(posedge clk);
      #1;
      vin = v;
      kin = k;
      for (int i = 0; i < IN_L; i++) begin
         din[DW*i +: DW] = seq;
         seq = seq + 1'b1;
      end
      @(negedge clk);
      check_cycle();
   endtask

   initial begin
      logic [DW-1:0] base;
      void'($urandom(32'd24681));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk((out_vld === '0) && (in_ready === 1'b1) && (refuse_cnt === '0), "R1 reset state",
          {out_vld, in_ready, refuse_cnt}, {3'b000, 1'b1, 16'h0});
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk((out_vld === '0) && (in_ready === 1'b1) && (refuse_cnt === '0), "R1 after release",
          {out_vld, in_ready, refuse_cnt}, {3'b000, 1'b1, 16'h0});

      // four reads into an empty FIFO: two read slots, same cycle
      base = seq;
      step(4'b1111, 8'b01_01_01_01);
      chk((out_vld === 3'b011) && (out_data[DW-1:0] === base), "R8 same-cycle delivery",
          {out_vld, out_data[DW-1:0]}, {3'b011, base});
      // held reads come back at the next edge
      step(4'b0000, 8'b0);
      chk((out_vld === 3'b011) && (out_data[DW-1:0] === DW'(base + 2)), "R4 deferred next edge",
          {out_vld, out_data[DW-1:0]}, {3'b011, DW'(base + 2)});
      // W,W,R,R: write dedicated, write shared, read dedicated, last read waits
      step(4'b1111, 8'b01_01_10_10);
      chk((out_vld === 3'b111) && (out_kind === 6'b01_10_10), "R2 dedicated before shared",
          {out_vld, out_kind}, {3'b111, 6'b01_10_10});
      // held read goes ahead of a new write
      base = seq;
      step(4'b0001, 8'b00_00_00_10);
      chk((out_vld === 3'b011) && (out_kind === 6'b00_10_01) && (out_data[2*DW-1:DW] === base),
          "R4 held response has priority", {out_vld, out_kind}, {3'b011, 6'b00_10_01});
      // illegal kind on lane 1
      step(4'b0011, 8'b00_00_11_01);
      chk((kind_err === 1'b1) && (out_vld === 3'b001), "R6 illegal lane dropped",
          {kind_err, out_vld}, {1'b1, 3'b001});
      // fill FIFO to exercise the overflow guard
      repeat (8) step(4'b1111, 8'b01_01_01_01);
      repeat (8) step(4'b0000, 8'b0);

      // random traffic
      for (int c = 0; c < 1500; c++) begin
         logic [IN_L-1:0]   v;
         logic [2*IN_L-1:0] k;
         for (int i = 0; i < IN_L; i++) begin
            v[i] = ($urandom % 10) < 7;
            k[2*i +: 2] = (($urandom % 16) == 0) ? 2'b11 : ((($urandom % 2) == 0) ? 2'b01 : 2'b10);
         end
         step(v, k);
      end
      repeat (6) step(4'b0000, 8'b0);
      chk(mq.size() == 0, "R4 all responses drained", 64'(mq.size()), 64'd0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule